// File: doc/BRIEF.md
# Region-Gated CRC-16 Stream Checker

This block checks the integrity of a serial bitstream by running a CRC-16 over selected regions of it and comparing the result with a transmitted check word. Upstream logic finds the frame and the protected fields. It marks each protected region with an open pulse, which carries a signed bit limit, and a close pulse. It then presents the expected CRC word and pulses a check strobe.

Inside a region, every accepted stream bit is counted. A positive limit caps the region: bits beyond the limit are dropped. If the region closes early, zero bits are fed one per clock until the count reaches the limit. A limit of zero or below means the region is taken at its exact length. All regions of a frame feed one shared CRC register, and region lengths need not be whole bytes.

When the check strobe is resolved, the block does three things. It reports a mismatch on a sticky-until-next-check error flag, pulses done, and rearms for the next frame.

Top module: `crc16_region_chk`

## Requirements
- R1: The CRC uses the polynomial 0x8005, non-reflected and MSB-first. For each bit, the feedback is the incoming bit XOR register bit 15, the register shifts left by one, and 0x8005 is XORed in when the feedback is 1. No final XOR is applied.
- R2: The CRC register is set to 0xFFFF at reset and again on every resolved check. Successive regions of one frame continue from the value left by the previous region.
- R3: When a region's limit (the 16-bit two's complement value `reg_limit`, sampled on the `reg_open` cycle) is positive and the region carries more bits than the limit, only the first limit bits enter the CRC and no padding occurs.
- R4: When the limit is positive and the region closes with fewer bits than the limit, the missing bits are fed as zeros after the close, one per clock. `ready` is low for exactly that many cycles.
- R5: When the limit is zero or negative, exactly the bits accepted between open and close enter the CRC, with no truncation and no padding.
- R6: Region lengths that are not a multiple of 8 give the same CRC as the bit-serial definition of R1 applied to the same bits.
- R7: A `check` pulse with the block idle makes `done` go high for exactly one cycle on the next clock edge. At that edge `crc_error` becomes 1 if the final CRC differs from `exp_crc` and 0 if it matches, and the region count returns to zero.
- R8: At most 4 regions open per frame. A `reg_open` with 4 regions already used is ignored, along with its bits and its close, and it sets `overflow`, which stays set until reset.
- R9: A `check` that arrives during a region or during padding is held. `done` appears only after padding has finished, with `ready` high.
- R10: `crc_error` changes only in the cycle where `done` is high.
- R11: Stream bits that arrive outside any region, or on the open or close cycle, leave the CRC unchanged.
- R12: After reset, `done`, `crc_error` and `overflow` are 0 and `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial stream data bit |
| bit_valid | input | 1 | Qualifies bit_in; a bit is taken when bit_valid and ready are both high |
| ready | output | 1 | Low while zero padding is in progress |
| reg_open | input | 1 | Region open pulse |
| reg_close | input | 1 | Region close pulse |
| reg_limit | input | 16 | Signed bit limit of the region being opened |
| exp_crc | input | 16 | Expected CRC word, held from check until done |
| check | input | 1 | Compare strobe ending a frame |
| done | output | 1 | One-cycle pulse when the comparison result is valid |
| crc_error | output | 1 | 1 when the last comparison mismatched |
| overflow | output | 1 | Sticky flag for a region open beyond the per-frame maximum |

## Verification
Several properties are checked on every cycle by the assertions:

- the CRC register holds its value whenever nothing is fed and returns to 0xFFFF after a check;
- padding never runs past the limit;
- a held check is not lost;
- the region count never exceeds its bound and the overflow flag is sticky;
- done is a single-cycle pulse that appears only with ready high;
- crc_error moves only with done.

Other behaviour can only be shown by the bench's scenarios, each compared against an independent byte-table and bit-serial model of the CRC. These scenarios cover the CRC values themselves, truncation and padding lengths, exact-length mode on unaligned regions, bits outside regions being ignored, and a deferred check.

// File: rtl/crc16_rc_pkg.sv
package crc16_rc_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_PAD  = 2'd2
  } rc_state_e;

  // One MSB-first shift step of the non-reflected CRC.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic d);
    logic fb;
    fb = d ^ c[CRC_W-1];
    crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  // A limit counts as a cap only when strictly positive.
  function automatic logic limit_is_cap(input logic [CRC_W-1:0] lim);
    limit_is_cap = ($signed(lim) > 0);
  endfunction
endpackage

// File: rtl/crc16_shift_reg.sv
module crc16_shift_reg
  import crc16_rc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             preset,
  input  logic             feed,
  input  logic             din,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || preset) crc_q <= CRC_INIT;
    else if (feed)     crc_q <= crc_step(crc_q, din);
  end

  assign crc_o = crc_q;

  // R11: no feed, no preset -> register untouched
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!feed && !preset) |=> $stable(crc_q));
  // R2: preset returns the register to its initial value
  p_preset_r2: assert property (@(posedge clk) disable iff (rst)
    preset |=> (crc_q == CRC_INIT));
endmodule

// File: rtl/region_len_ctr.sv
module region_len_ctr
  import crc16_rc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] limit_in,
  input  logic             step,
  output logic             keep_bit,
  output logic             short_fill,
  output logic             last_pad
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             capped_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      cap_q    <= '0;
      capped_q <= 1'b0;
    end else if (start) begin
      cnt_q    <= '0;
      cap_q    <= limit_in;
      capped_q <= ($signed(limit_in) > 0);
    end else if (step && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign keep_bit   = !capped_q || (cnt_q < cap_q);
  assign short_fill = capped_q && (cnt_q < cap_q);
  assign last_pad   = capped_q && (cnt_q == cap_q - 1'b1);

  // R4: the final pad step brings the count exactly to the cap
  p_fill_stops_at_cap_r4: assert property (@(posedge clk) disable iff (rst)
    (step && last_pad && !start) |=> !short_fill);
  // R3: once the cap is reached, further bits are never kept
  p_trunc_persists_r3: assert property (@(posedge clk) disable iff (rst)
    (!keep_bit && !start) |=> !keep_bit);
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import crc16_rc_pkg::*;
#(
  parameter int MAX_REG = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic open_i,
  input  logic close_i,
  input  logic check_i,
  input  logic bit_valid,
  input  logic short_fill,
  input  logic last_pad,
  output logic region_start,
  output logic accept,
  output logic pad_step,
  output logic fire,
  output logic ready,
  output logic overflow
);
  localparam int UW = $clog2(MAX_REG + 1);
  localparam logic [UW-1:0] USED_MAX = UW'(MAX_REG);

  rc_state_e     state_q;
  logic [UW-1:0] used_q;
  logic          pend_q;
  logic          ovf_q;

  assign fire         = (state_q == ST_IDLE) && (check_i || pend_q);
  assign region_start = (state_q == ST_IDLE) && !fire && open_i && (used_q < USED_MAX);
  assign accept       = (state_q == ST_OPEN) && bit_valid && !close_i;
  assign pad_step     = (state_q == ST_PAD);
  assign ready        = (state_q != ST_PAD);
  assign overflow     = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      used_q  <= '0;
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fire) begin
            used_q <= '0;
            pend_q <= 1'b0;
          end else if (open_i) begin
            if (used_q == USED_MAX) ovf_q <= 1'b1;
            else begin
              used_q  <= used_q + 1'b1;
              state_q <= ST_OPEN;
            end
          end
        end
        ST_OPEN: begin
          if (check_i) pend_q <= 1'b1;
          if (close_i) state_q <= short_fill ? ST_PAD : ST_IDLE;
        end
        ST_PAD: begin
          if (check_i) pend_q <= 1'b1;
          if (last_pad) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: region count never passes the per-frame maximum
  p_used_bound_r8: assert property (@(posedge clk) disable iff (rst)
    used_q <= USED_MAX);
  // R8: overflow is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  // R9: a held check is kept until it can be resolved
  p_pend_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (pend_q && (state_q != ST_IDLE)) |=> pend_q);
  // R4: padding continues until the last pad step
  p_pad_runs_r4: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_PAD) && !last_pad) |=> (state_q == ST_PAD));
endmodule

// File: rtl/crc16_region_chk.sv
module crc16_region_chk
  import crc16_rc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_REG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_valid,
  output logic             ready,
  input  logic             reg_open,
  input  logic             reg_close,
  input  logic [CNT_W-1:0] reg_limit,
  input  logic [CRC_W-1:0] exp_crc,
  input  logic             check,
  output logic             done,
  output logic             crc_error,
  output logic             overflow
);
  // Named internal events
  logic             region_start;
  logic             accept;
  logic             pad_step;
  logic             fire;
  logic             keep_bit;
  logic             short_fill;
  logic             last_pad;
  logic             crc_feed;
  logic             crc_din;
  logic [CRC_W-1:0] crc_now;
  logic             done_q;
  logic             err_q;

  frame_seq #(.MAX_REG(MAX_REG)) u_seq (
    .clk(clk), .rst(rst),
    .open_i(reg_open), .close_i(reg_close), .check_i(check),
    .bit_valid(bit_valid), .short_fill(short_fill), .last_pad(last_pad),
    .region_start(region_start), .accept(accept), .pad_step(pad_step),
    .fire(fire), .ready(ready), .overflow(overflow)
  );

  region_len_ctr #(.CNT_W(CNT_W)) u_len (
    .clk(clk), .rst(rst),
    .start(region_start), .limit_in(reg_limit),
    .step(accept || pad_step),
    .keep_bit(keep_bit), .short_fill(short_fill), .last_pad(last_pad)
  );

  assign crc_feed = (accept && keep_bit) || pad_step;
  assign crc_din  = pad_step ? 1'b0 : bit_in;

  crc16_shift_reg u_crc (
    .clk(clk), .rst(rst),
    .preset(fire), .feed(crc_feed), .din(crc_din),
    .crc_o(crc_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= fire;
      if (fire) err_q <= (crc_now != exp_crc);
    end
  end

  assign done      = done_q;
  assign crc_error = err_q;

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R10: the error flag moves only alongside done
  p_err_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(err_q));
  // R9: the result never appears while padding is underway
  p_done_after_fill_r9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ready);
  // R2: each frame result leaves the register rearmed
  p_rearm_r2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (crc_now == CRC_INIT));
endmodule

// File: tb/crc16_region_chk_test.sv
module crc16_region_chk_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_in = 1'b0, bit_valid = 1'b0;
  logic        reg_open = 1'b0, reg_close = 1'b0, check = 1'b0;
  logic [15:0] reg_limit = '0;
  logic [15:0] exp_crc = '0;
  logic        ready, done, crc_error, overflow;

  int tests = 0, fails = 0;
  bit finished = 0;
  bit mbits[$];            // bits the model feeds into the CRC
  bit exp_q[$];            // scoreboard: expected crc_error per check
  string tag_q[$];
  logic [15:0] lf = 16'hACE1;
  bit prev_done = 0;

  always #5 clk = ~clk;

  crc16_region_chk uut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid), .ready(ready),
    .reg_open(reg_open), .reg_close(reg_close), .reg_limit(reg_limit),
    .exp_crc(exp_crc), .check(check), .done(done), .crc_error(crc_error),
    .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Model: byte-table for whole bytes, bit-serial for the tail
  function automatic logic [15:0] tab(input logic [7:0] i);
    logic [15:0] v;
    v = {i, 8'h00};
    for (int k = 0; k < 8; k++) v = v[15] ? ((v << 1) ^ 16'h8005) : (v << 1);
    return v;
  endfunction

  function automatic logic [15:0] model_crc();
    logic [15:0] c;
    logic [7:0] by;
    int n, i;
    c = 16'hFFFF;
    n = mbits.size();
    i = 0;
    while (n - i >= 8) begin
      by = '0;
      for (int k = 0; k < 8; k++) by = {by[6:0], mbits[i+k]};
      c = (c << 8) ^ tab(c[15:8] ^ by);
      i += 8;
    end
    while (i < n) begin
      if (mbits[i] ^ c[15]) c = (c << 1) ^ 16'h8005;
      else c = c << 1;
      i++;
    end
    return c;
  endfunction

  function automatic bit next_bit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  // Monitor: pops the scoreboard when done appears
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) chk(0, "R7 done longer than one cycle", 1, 0);
      if (done) begin
        chk(ready, "R9 done while padding", ready, 1);
        if (exp_q.size() == 0) chk(0, "R7 unexpected done", 1, 0);
        else begin
          automatic bit e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(crc_error == e, t, crc_error, e);
        end
      end
      prev_done = done;
    end
  end

  task automatic idle_bits(input int n);
    for (int k = 0; k < n; k++) begin
      bit_valid = 1'b1; bit_in = next_bit();
      @(negedge clk);
    end
    bit_valid = 1'b0;
  endtask

  // Driver: one region; counted=0 means the open is expected to be ignored
  task automatic do_region(input int n, input int lim, input bit counted,
                           input bit early, input bit bad, input string tag);
    int padc, want;
    reg_open = 1'b1; reg_limit = 16'(lim);
    @(negedge clk);
    reg_open = 1'b0;
    for (int k = 0; k < n; k++) begin
      bit_valid = 1'b1; bit_in = next_bit();
      if (counted && (lim <= 0 || k < lim)) mbits.push_back(bit_in);
      @(negedge clk);
    end
    bit_valid = 1'b0;
    want = (counted && lim > 0 && n < lim) ? lim - n : 0;
    for (int k = 0; k < want; k++) mbits.push_back(1'b0);
    // close cycle also carries a stream bit that must be ignored (R11)
    reg_close = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    reg_close = 1'b0; bit_valid = 1'b0;
    if (early) begin
      logic [15:0] m;
      m = model_crc();
      exp_crc = bad ? (m ^ 16'h0100) : m;
      exp_q.push_back(bad); tag_q.push_back({tag, " deferred check"});
      mbits.delete();
      check = 1'b1;
      @(negedge clk);
      check = 1'b0;
      while (!ready) @(negedge clk);
    end else begin
      padc = 0;
      while (!ready && padc < 70000) begin padc++; @(negedge clk); end
      chk(padc == want, {tag, " pad length"}, padc, want);
    end
  endtask

  task automatic wait_done();
    int t = 0;
    while (exp_q.size() != 0 && t < 100) begin t++; @(negedge clk); end
    chk(exp_q.size() == 0, "R7 done missing", exp_q.size(), 0);
  endtask

  task automatic do_check(input bit bad, input string tag);
    logic [15:0] m;
    m = model_crc();
    exp_crc = bad ? (m ^ 16'h0001) : m;
    exp_q.push_back(bad); tag_q.push_back(tag);
    mbits.delete();
    check = 1'b1;
    @(negedge clk);
    check = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(done == 0, "R12 done after reset", done, 0);
    chk(crc_error == 0, "R12 crc_error after reset", crc_error, 0);
    chk(overflow == 0, "R12 overflow after reset", overflow, 0);
    chk(ready == 1, "R12 ready after reset", ready, 1);

    // Frame A: exact-length regions, unaligned, idle bits between (R1 R5 R6 R11)
    do_region(24, 0, 1, 0, 0, "R5 exact zero limit");
    idle_bits(7);
    do_region(13, -1, 1, 0, 0, "R6 unaligned negative limit");
    idle_bits(3);
    do_check(0, "R1 R11 frame A match");

    // Frame B: truncation, padding, exact fit, empty padded region (R3 R4 R2)
    do_region(40, 20, 1, 0, 0, "R3 truncation");
    do_region(5, 12, 1, 0, 0, "R4 short region padding");
    do_region(11, 11, 1, 0, 0, "R3 exact fit");
    do_region(0, 3, 1, 0, 0, "R4 empty region padding");
    do_check(1, "R2 R7 frame B mismatch");
    // R10: crc_error holds after done although exp_crc changes
    exp_crc = ~exp_crc;
    repeat (10) @(negedge clk);
    chk(crc_error == 1, "R10 crc_error held", crc_error, 1);

    // Frame C: four regions again accepted after check cleared count (R7 R2)
    do_region(9, 0, 1, 0, 0, "R7 region 1 after clear");
    do_region(17, 8, 1, 0, 0, "R3 region 2 after clear");
    do_region(3, 0, 1, 0, 0, "R5 region 3 after clear");
    do_region(1, 2, 1, 0, 0, "R4 region 4 after clear");
    chk(overflow == 0, "R7 count cleared by check", overflow, 0);
    do_check(0, "R2 frame C match restarts from preset");
    chk(crc_error == 0, "R10 crc_error updated at done", crc_error, 0);

    // Frame D: check pulsed during padding (R9)
    do_region(6, 14, 1, 1, 0, "R9");
    wait_done();

    // Frame E: fifth region ignored, overflow set (R8)
    do_region(8, 0, 1, 0, 0, "R8 region 1");
    do_region(10, 0, 1, 0, 0, "R8 region 2");
    do_region(4, 6, 1, 0, 0, "R8 region 3");
    do_region(12, 0, 1, 0, 0, "R8 region 4");
    do_region(9, 20, 0, 0, 0, "R8 ignored fifth region");
    chk(overflow == 1, "R8 overflow set", overflow, 1);
    do_check(0, "R8 fifth region excluded");

    // Frame F: overflow sticky across frames
    do_region(9, 0, 1, 0, 0, "R5 frame F");
    do_check(1, "R7 frame F mismatch");
    chk(overflow == 1, "R8 overflow sticky", overflow, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule